// File: doc/BRIEF.md
# Dual-Event Interrupt Status Unit

This block keeps the interrupt state for two event sources: a delay event and an overflow event. Each event arrives as a one-cycle strobe from the counting logic next to it. The block latches each strobe into a raw status bit. It combines the raw bits with an interrupt enable vector to form masked status bits, and it drives a level interrupt output from them. A second enable vector gates the raw bits onto a wake-up request output.

Software reaches the state through a 32-bit register interface with a single-cycle write strobe and a combinational read port. Five locations are decoded:

| Offset | Location | Write behaviour | Read value |
|---|---|---|---|
| 0x00 | raw status | a 1 sets the bit, to force an event for debug | raw vector |
| 0x04 | masked status | a 1 clears the underlying raw bit | raw AND enable |
| 0x08 | enable set | a 1 sets the enable bit | enable vector |
| 0x0C | enable clear | a 1 clears the enable bit | enable vector |
| 0x10 | wake-up enable | plain read/write | wake-up enable vector |

The delay event sits in bit 1 and the overflow event in bit 0.

Top module: `evirq_unit`

## Requirements
- R1: Only bits 1 (delay) and 0 (overflow) are implemented. Bits 31:2 of every location read as 0, and writes to those bits change nothing.
- R2: A strobe on an event input sets that event's raw bit (offset 0x00) on the next clock, whether or not its interrupt is enabled.
- R3: Writing 1 to a bit at offset 0x00 sets that raw bit. Writing 0 leaves it unchanged.
- R4: A bit read at offset 0x04 is 1 exactly when both its raw bit and its enable bit are 1.
- R5: Writing 1 to a bit at offset 0x04 clears that raw bit, whether or not the event is enabled. Writing 0 leaves it unchanged.
- R6: Writing 1 to a bit at offset 0x08 sets that enable bit. Writing 1 at offset 0x0C clears it. Writing 0 to either location has no effect.
- R7: Reads at offsets 0x08 and 0x0C both return the current enable vector.
- R8: The wake-up enable vector at offset 0x10 takes the written value and reads it back.
- R9: `irq` is the OR of the masked bits. It holds as a level until the masked bits are cleared.
- R10: `wake_req` is 1 exactly when some raw bit and its wake-up enable bit are both 1.
- R11: If an event strobe and a software clear of the same bit come in the same cycle, the bit ends up set.
- R12: While `rst_n` is low, the raw vector, the enable vector and the wake-up enable vector are all 0. After reset, every location reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dly_evt | input | 1 | Delay event strobe, one cycle |
| ovf_evt | input | 1 | Overflow event strobe, one cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt |
| wake_req | output | 1 | Wake-up request |

## Verification
The bench sets the delay bit from an event while its interrupt is disabled. A design that gated raw capture with the enable would lose that event. The bench clears the overflow bit through the masked view with the overflow interrupt disabled. A design that cleared only enabled bits would leave the raw bit stuck. It also writes zeros to the set and clear locations, where a design that loaded the data plainly would wipe the enables. Finally, it fires an event in the same cycle as a clear of that bit, where a design that favoured software would drop the event and leave `irq` low.

// File: rtl/evirq_pkg.sv
package evirq_pkg;
  localparam int unsigned EV_N   = 2;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 32;

  localparam int unsigned BIT_OVF = 0;
  localparam int unsigned BIT_DLY = 1;

  localparam logic [ADDR_W-1:0] OFS_RAW    = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_EN_SET = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_WAKE   = 6'h10;

  typedef logic [EV_N-1:0] ev_vec_t;

  function automatic ev_vec_t gate_vec(ev_vec_t a, ev_vec_t b);
    return a & b;
  endfunction

  function automatic logic any_set(ev_vec_t v);
    return |v;
  endfunction

  function automatic logic [DATA_W-1:0] widen(ev_vec_t v);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EV_N-1:0] = v;
    return w;
  endfunction
endpackage

// File: rtl/evirq_raw_cell.sv
module evirq_raw_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic sw_set,
  input  logic sw_clr,
  output logic raw_q
);
  logic raw_d;
  logic hold;

  assign hold  = ~evt & ~sw_set & ~sw_clr;
  // An event or a software set wins over a clear in the same cycle.
  assign raw_d = evt | sw_set | (raw_q & ~sw_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= raw_d;
  end

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> raw_q);
  a_r11_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && sw_clr) |=> raw_q);
  a_r3_sw_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set |=> raw_q);
  a_r5_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !evt && !sw_set) |=> !raw_q);
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(raw_q));
endmodule

// File: rtl/evirq_en_bank.sv
module evirq_en_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] en_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        en_q[i] <= 1'b0;
      else if (set_v[i]) en_q[i] <= 1'b1;
      else if (clr_v[i]) en_q[i] <= 1'b0;
    end

    a_r6_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[i] |=> en_q[i]);
    a_r6_clr_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v[i] && !set_v[i]) |=> !en_q[i]);
    a_r6_idle_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_v[i] && !set_v[i]) |=> $stable(en_q[i]));
  end
endmodule

// File: rtl/evirq_regif.sv
module evirq_regif
  import evirq_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  ev_vec_t           raw_v,
  input  ev_vec_t           en_v,
  input  ev_vec_t           wake_v,
  output ev_vec_t           raw_set,
  output ev_vec_t           raw_clr,
  output ev_vec_t           en_set,
  output ev_vec_t           en_clr,
  output ev_vec_t           wake_set,
  output ev_vec_t           wake_clr,
  output logic [DATA_W-1:0] rdata
);
  ev_vec_t wd;
  logic    hit_raw, hit_msk, hit_set, hit_clr, hit_wake;

  assign wd       = wdata[EV_N-1:0];
  assign hit_raw  = wr_en && (addr == OFS_RAW);
  assign hit_msk  = wr_en && (addr == OFS_MASKED);
  assign hit_set  = wr_en && (addr == OFS_EN_SET);
  assign hit_clr  = wr_en && (addr == OFS_EN_CLR);
  assign hit_wake = wr_en && (addr == OFS_WAKE);

  assign raw_set  = hit_raw  ? wd  : '0;
  assign raw_clr  = hit_msk  ? wd  : '0;
  assign en_set   = hit_set  ? wd  : '0;
  assign en_clr   = hit_clr  ? wd  : '0;
  assign wake_set = hit_wake ? wd  : '0;
  assign wake_clr = hit_wake ? ~wd : '0;

  always_comb begin
    unique case (addr)
      OFS_RAW:    rdata = widen(raw_v);
      OFS_MASKED: rdata = widen(gate_vec(raw_v, en_v));
      OFS_EN_SET,
      OFS_EN_CLR: rdata = widen(en_v);
      OFS_WAKE:   rdata = widen(wake_v);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/evirq_unit.sv
module evirq_unit
  import evirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dly_evt,
  input  logic              ovf_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              wake_req
);
  ev_vec_t evt_v, raw_v, en_v, wake_v;
  ev_vec_t raw_set, raw_clr, en_set, en_clr, wake_set, wake_clr;
  ev_vec_t masked_v, wake_hit_v;

  always_comb begin
    evt_v          = '0;
    evt_v[BIT_DLY] = dly_evt;
    evt_v[BIT_OVF] = ovf_evt;
  end

  evirq_regif u_regif (
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .raw_v(raw_v), .en_v(en_v), .wake_v(wake_v),
    .raw_set(raw_set), .raw_clr(raw_clr),
    .en_set(en_set), .en_clr(en_clr),
    .wake_set(wake_set), .wake_clr(wake_clr),
    .rdata(rdata)
  );

  for (genvar i = 0; i < EV_N; i++) begin : g_raw
    evirq_raw_cell u_cell (
      .clk(clk), .rst_n(rst_n), .evt(evt_v[i]),
      .sw_set(raw_set[i]), .sw_clr(raw_clr[i]), .raw_q(raw_v[i])
    );
  end

  evirq_en_bank #(.N(EV_N)) u_irq_en (
    .clk(clk), .rst_n(rst_n), .set_v(en_set), .clr_v(en_clr), .en_q(en_v)
  );

  evirq_en_bank #(.N(EV_N)) u_wake_en (
    .clk(clk), .rst_n(rst_n), .set_v(wake_set), .clr_v(wake_clr), .en_q(wake_v)
  );

  assign masked_v   = gate_vec(raw_v, en_v);
  assign wake_hit_v = gate_vec(raw_v, wake_v);
  assign irq        = any_set(masked_v);
  assign wake_req   = any_set(wake_hit_v);

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:EV_N] == '0);
  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(|raw_clr) && !(|en_clr)) |=> irq);
  a_r10_wake_source: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (|raw_v) && (|wake_v));
  a_r12_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (raw_v == '0) && (en_v == '0) && (wake_v == '0));
endmodule

// File: tb/evirq_unit_test.sv
`timescale 1ns/1ps
module evirq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dly_evt = 1'b0, ovf_evt = 1'b0, wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wake_req;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [5:0] A_RAW = 6'h00, A_MSK = 6'h04, A_SET = 6'h08,
                         A_CLR = 6'h0C, A_WAKE = 6'h10;

  evirq_unit uut (.clk(clk), .rst_n(rst_n), .dly_evt(dly_evt), .ovf_evt(ovf_evt),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
    .wake_req(wake_req));

  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_check(string req, logic [5:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic pulse(logic d, logic o);
    @(negedge clk);
    dly_evt = d; ovf_evt = o;
    @(negedge clk);
    dly_evt = 1'b0; ovf_evt = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    rd_check("R12 raw", A_RAW, 0);
    rd_check("R12 masked", A_MSK, 0);
    rd_check("R12 en", A_SET, 0);
    rd_check("R12 wake", A_WAKE, 0);
    check("R12 irq", {31'd0, irq}, 0);
    check("R12 wake_req", {31'd0, wake_req}, 0);
  endtask

  task automatic t_event_disabled();
    pulse(1'b1, 1'b0);
    rd_check("R2 dly raw set while disabled", A_RAW, 32'h2);
    rd_check("R4 masked zero when disabled", A_MSK, 0);
    check("R9 irq low when disabled", {31'd0, irq}, 0);
  endtask

  task automatic t_sw_set();
    wr(A_RAW, 32'h0);
    rd_check("R3 write 0 no effect", A_RAW, 32'h2);
    wr(A_RAW, 32'h1);
    rd_check("R3 write 1 sets ovf", A_RAW, 32'h3);
  endtask

  task automatic t_enables();
    wr(A_SET, 32'h2);
    rd_check("R7 read set addr", A_SET, 32'h2);
    rd_check("R7 read clr addr", A_CLR, 32'h2);
    wr(A_SET, 32'h0);
    rd_check("R6 set 0 no effect", A_SET, 32'h2);
    wr(A_CLR, 32'h0);
    rd_check("R6 clr 0 no effect", A_CLR, 32'h2);
    rd_check("R4 masked dly", A_MSK, 32'h2);
    check("R9 irq high", {31'd0, irq}, 1);
    repeat (4) @(negedge clk);
    check("R9 irq holds level", {31'd0, irq}, 1);
  endtask

  task automatic t_clear();
    wr(A_MSK, 32'h1);
    rd_check("R5 clear disabled ovf", A_RAW, 32'h2);
    check("R9 irq still high", {31'd0, irq}, 1);
    wr(A_MSK, 32'h2);
    rd_check("R5 clear dly", A_RAW, 32'h0);
    check("R9 irq low after clear", {31'd0, irq}, 0);
    wr(A_CLR, 32'h2);
    rd_check("R6 clr 1 clears", A_SET, 32'h0);
  endtask

  task automatic t_upper_bits();
    wr(A_RAW, 32'hFFFF_FFFC);
    rd_check("R1 upper raw bits ignored", A_RAW, 32'h0);
    wr(A_SET, 32'hFFFF_FFFF);
    rd_check("R1 enable reads two bits", A_SET, 32'h3);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd_check("R6 clear all enables", A_CLR, 32'h0);
  endtask

  task automatic t_wake();
    wr(A_WAKE, 32'h1);
    rd_check("R8 wake readback", A_WAKE, 32'h1);
    check("R10 no raw no wake", {31'd0, wake_req}, 0);
    pulse(1'b1, 1'b0);
    check("R10 dly not wake enabled", {31'd0, wake_req}, 0);
    pulse(1'b0, 1'b1);
    check("R10 ovf wakes", {31'd0, wake_req}, 1);
    wr(A_WAKE, 32'h0);
    rd_check("R8 wake cleared", A_WAKE, 32'h0);
    check("R10 wake off", {31'd0, wake_req}, 0);
    wr(A_MSK, 32'h3);
    rd_check("R5 clear both", A_RAW, 32'h0);
  endtask

  task automatic t_collision();
    wr(A_SET, 32'h1);
    @(negedge clk);
    wr_en = 1'b1; addr = A_MSK; wdata = 32'h1; ovf_evt = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; ovf_evt = 1'b0;
    rd_check("R11 event beats clear", A_RAW, 32'h1);
    check("R11 irq stays", {31'd0, irq}, 1);
  endtask

  task automatic t_reset_mid();
    wr(A_WAKE, 32'h3);
    do_reset();
    rd_check("R12 raw after mid reset", A_RAW, 0);
    rd_check("R12 en after mid reset", A_CLR, 0);
    rd_check("R12 wake after mid reset", A_WAKE, 0);
    check("R12 irq after mid reset", {31'd0, irq}, 0);
  endtask

  initial begin
    t_reset();
    t_event_disabled();
    t_sw_set();
    t_enables();
    t_clear();
    t_upper_bits();
    t_wake();
    t_collision();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule